// File: doc/BRIEF.md
# Immediate Codec Command Register Interface

This block lets software exchange a single command word with an external codec without setting up a command ring. Software loads a 32-bit command register, then sets a busy bit in a 16-bit status register. Setting that bit is the launch itself: the block emits a one-cycle send request on the link side, carrying the held command word. When the link returns a response strobe, the block stores the response word, drops busy and raises a sticky valid flag, all on one clock edge.

Software polls busy until it reads 0, reads the response register and then clears the valid flag by writing a 1 to it. Clearing valid before each new command lets software tell when a fresh response has arrived. Responses that arrive while no command is outstanding are thrown away. Serial framing, the ring mechanism and interrupts belong to other blocks.

Top module: `imm_cmd_regs`

## Requirements
- R1: After reset the status register reads 0000h, the command and response registers read 0, and the send request is low.
- R2: The status register is at offset 68h and is zero-extended on the 32-bit read bus. Bit 0 is busy, bit 1 is valid, and bits 15:2 always read 0 whatever value is written.
- R3: The command register at offset 60h can be written and read back while busy is 0.
- R4: A write of 1 to status bit 0 while busy is 0 sets busy. The send request is high for exactly the one cycle after that write, and the send word then equals the command register.
- R5: While busy is 1, writes to the command register are ignored and the send word holds steady.
- R6: A write of 1 to status bit 0 while busy is already 1 raises no second send request. A write of 0 to status bit 0 never clears busy.
- R7: A response strobe while busy is 1 stores the response word in the response register at offset 64h. On the same edge it clears busy and sets valid.
- R8: A response strobe while busy is 0 is discarded, leaving the response register and the valid flag unchanged.
- R9: Writing 1 to status bit 1 clears valid. Writing 0 to status bit 1 leaves valid unchanged.
- R10: If a clear of valid and a response latch fall on the same cycle, valid ends up set.
- R11: The response register is read-only, so writes to offset 64h leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, selected by addr |
| sendReq | output | 1 | One-cycle command launch pulse to the link |
| sendWord | output | 32 | Command word offered to the link |
| rspValid | input | 1 | Response strobe from the link |
| rspWord | input | 32 | Response word from the link |

## Verification
On every cycle, the embedded assertions check these rules:
- the send request is a single pulse and occurs only while busy is set;
- a strobe that arrives while busy is set hands over from busy to valid on the next edge;
- busy holds without a strobe;
- the command register stays frozen while busy;
- the response register does not move while idle;
- a write-one clear of valid takes effect.

Some behaviour only the bench scenarios can show. This covers the reserved status bits, the values read back at each offset, and the discarding of stray strobes as seen through the read bus. It also covers the absence of a second launch, the ignored zero writes, and the outcome when a clear and a set collide.

// File: rtl/imm_cmd_pkg.sv
package imm_cmd_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STAT_W = 16;

  localparam logic [ADDR_W-1:0] CMD_OFS  = 8'h60;
  localparam logic [ADDR_W-1:0] RSP_OFS  = 8'h64;
  localparam logic [ADDR_W-1:0] STAT_OFS = 8'h68;

  localparam int BUSY_BIT  = 0;
  localparam int VALID_BIT = 1;

  typedef struct packed {
    logic cmdWr;     // command register load enable
    logic rspLatch;  // response register capture enable
  } ctlStrobes_t;
endpackage

// File: rtl/imm_cmd_ctrl.sv
module imm_cmd_ctrl
  import imm_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wrFlags,
  input  logic              rspValid,
  output ctlStrobes_t       strobes,
  output logic              busy,
  output logic              valid,
  output logic              sendReq
);
  logic statWr, launch, clearValid, latchRsp;

  assign statWr     = wrEn && (addr == STAT_OFS);
  assign launch     = statWr && wrFlags[BUSY_BIT] && !busy;
  assign clearValid = statWr && wrFlags[VALID_BIT];
  assign latchRsp   = rspValid && busy;

  assign strobes.cmdWr    = wrEn && (addr == CMD_OFS) && !busy;
  assign strobes.rspLatch = latchRsp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      valid   <= 1'b0;
      sendReq <= 1'b0;
    end else begin
      sendReq <= launch;
      if (latchRsp)    busy <= 1'b0;
      else if (launch) busy <= 1'b1;
      if (latchRsp)        valid <= 1'b1;
      else if (clearValid) valid <= 1'b0;
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |=> !sendReq);
  // R4
  send_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendReq |-> busy);
  // R7
  latch_handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rspValid) |=> (valid && !busy));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rspValid) |=> busy);
  // R9
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && statWr && wrFlags[VALID_BIT] && !rspValid) |=> !valid);
endmodule

// File: rtl/imm_cmd_dp.sv
module imm_cmd_dp
  import imm_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              busyIn,
  input  logic              validIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rspWord,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] sendWord
);
  localparam int PAD_W = DATA_W - STAT_W;
  localparam int RSV_W = STAT_W - 2;

  logic [DATA_W-1:0] cmdReg, rspReg;
  logic [STAT_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      rspReg <= '0;
    end else begin
      if (strobes.cmdWr)    cmdReg <= wrData;
      if (strobes.rspLatch) rspReg <= rspWord;
    end
  end

  assign statusWord = {{RSV_W{1'b0}}, validIn, busyIn};
  assign sendWord   = cmdReg;

  always_comb begin
    case (addr)
      CMD_OFS:  rdData = cmdReg;
      RSP_OFS:  rdData = rspReg;
      STAT_OFS: rdData = {{PAD_W{1'b0}}, statusWord};
      default:  rdData = '0;
    endcase
  end

  // R5
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(cmdReg));
  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyIn && $past(!busyIn)) |-> $stable(rspReg));
endmodule

// File: rtl/imm_cmd_regs.sv
module imm_cmd_regs
  import imm_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sendReq,
  output logic [DATA_W-1:0] sendWord,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspWord
);
  ctlStrobes_t strobes;
  logic busy, valid;

  imm_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrFlags(wrData[1:0]), .rspValid(rspValid), .strobes(strobes),
    .busy(busy), .valid(valid), .sendReq(sendReq)
  );

  imm_cmd_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busyIn(busy),
    .validIn(valid), .addr(addr), .wrData(wrData), .rspWord(rspWord),
    .rdData(rdData), .sendWord(sendWord)
  );
endmodule

// File: tb/sim_imm_cmd_regs.sv
module sim_imm_cmd_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic sendReq;
  logic [31:0] sendWord;
  logic rspValid = 1'b0;
  logic [31:0] rspWord = '0;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] CMD = 8'h60, RSP = 8'h64, STAT = 8'h68;

  always #4 clk = ~clk;  // 125 MHz

  imm_cmd_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sendReq(sendReq), .sendWord(sendWord),
    .rspValid(rspValid), .rspWord(rspWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic respond(input logic [31:0] w);
    rspValid = 1'b1; rspWord = w;
    @(negedge clk);
    rspValid = 1'b0; rspWord = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] lastRsp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    rdReg(STAT, v); chk("R1 status", v, 32'h0);
    rdReg(CMD, v);  chk("R1 cmd", v, 32'h0);
    rdReg(RSP, v);  chk("R1 rsp", v, 32'h0);
    chk("R1 sendReq", {31'b0, sendReq}, 32'h0);
    // R2 reserved bits ignore writes
    wrReg(STAT, 32'hFFFF_FFFC);
    rdReg(STAT, v); chk("R2 reserved", v, 32'h0);
    rdReg(8'h6C, v); chk("R2 unmapped", v, 32'h0);
    lastRsp = '0;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] cmdVal, rspVal;
      cmdVal = (i * 32'h0101_0107) ^ (32'h1 << i[4:0]);
      rspVal = ~cmdVal + i;
      // R3
      wrReg(CMD, cmdVal);
      rdReg(CMD, v); chk("R3 cmd readback", v, cmdVal);
      // R8 stray strobe while idle
      respond(cmdVal ^ 32'h5A5A_5A5A);
      rdReg(RSP, v); chk("R8 rsp kept", v, lastRsp);
      rdReg(STAT, v); chk("R8 status idle", v, 32'h0);
      // R4 launch
      wrReg(STAT, 32'h1 | (i[0] ? 32'hFFF0 : 32'h0));
      chk("R4 pulse high", {31'b0, sendReq}, 32'h1);
      chk("R4 sendWord", sendWord, cmdVal);
      rdReg(STAT, v); chk("R4 busy", v, 32'h1);
      // R5 command write ignored, sendReq drops after one cycle
      wrReg(CMD, ~cmdVal);
      chk("R4 pulse single", {31'b0, sendReq}, 32'h0);
      rdReg(CMD, v); chk("R5 cmd frozen", v, cmdVal);
      chk("R5 sendWord stable", sendWord, cmdVal);
      // R6 relaunch and zero write
      wrReg(STAT, 32'h1);
      chk("R6 no relaunch", {31'b0, sendReq}, 32'h0);
      wrReg(STAT, 32'h0);
      rdReg(STAT, v); chk("R6 busy held", v, 32'h1);
      // R11 response register read-only
      wrReg(RSP, 32'hDEAD_0000 + i);
      rdReg(RSP, v); chk("R11 rsp read-only", v, lastRsp);
      // R7 response latch
      respond(rspVal);
      lastRsp = rspVal;
      rdReg(STAT, v); chk("R7 busy->valid", v, 32'h2);
      rdReg(RSP, v);  chk("R7 rsp word", v, rspVal);
      // R9 zero write keeps valid, one write clears
      wrReg(STAT, 32'h0);
      rdReg(STAT, v); chk("R9 valid kept", v, 32'h2);
      wrReg(STAT, 32'h2);
      rdReg(STAT, v); chk("R9 valid cleared", v, 32'h0);
    end
    // R10 simultaneous clear and set
    wrReg(CMD, 32'h1234_5678);
    wrReg(STAT, 32'h1);
    wrEn = 1'b1; addr = STAT; wrData = 32'h2;
    rspValid = 1'b1; rspWord = 32'hCAFE_F00D;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; rspValid = 1'b0; rspWord = '0;
    rdReg(STAT, v); chk("R10 set wins", v, 32'h2);
    rdReg(RSP, v);  chk("R10 rsp", v, 32'hCAFE_F00D);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule